// File: doc/BRIEF.md
# PRBS Word Alignment Monitor

The block watches a 16-bit word stream coming out of a serial receiver whose word boundary is unknown. It assumes the far end sends a PRBS-15 pattern sixteen bits per clock. From each new word and the one before it, the block builds sixteen shifted candidate words. A dwell timer walks through these candidates one at a time. For the candidate in use, the block predicts the next word from the current one and compares the prediction with the word that actually arrives.

A correct prediction freezes the timer, so a candidate that keeps predicting well stays selected. Each wrong prediction advances the timer, so a candidate that keeps failing is dropped after its dwell period. Every mismatch appears as a one-cycle pulse on the raw error output. A separate burst filter drives the link error output, so a deliberately inverted word, which produces two error cycles, does not reach link status. A lock flag reports whether the prediction has been clean for long enough.

The block is placed between the receiver's parallel output and the link status logic. A latency measurement circuit can time single-word corruptions from the raw error pulse.

Top module: `prbs_align_mon`

## Requirements
- R1: While reset is low, lock_o, err_o and link_err_o are 0 and data_o is 0x0000. Asserting reset clears these outputs at once, without waiting for a clock. After release, candidate 0 is selected and the dwell timer starts from zero.
- R2: Take the 32-bit window {previous input word, current input word}, with the previous word in bits 31:16. Candidate s (0..15) is bits s+15..s of that window, so candidate 0 is the current word. data_o is the selected candidate and shows an input word three clocks after the edge that samples it.
- R3: Each mispredicted clock advances the dwell timer by one. After 128 advances the selection steps from candidate s to candidate s+1, and from candidate 15 it wraps to candidate 0.
- R4: A correct prediction leaves the timer unchanged, so a clean stream keeps candidate 0 selected indefinitely, with data_o equal to the input word from three clocks earlier.
- R5: The prediction follows the PRBS-15 rule b[n] = b[n-15] xor b[n-14], with bit 15 of each word as the earliest bit. It extends the current selected word by sixteen bits. err_o is high for exactly the clocks in which this prediction differs from the next selected word. The pulse appears four clocks after the input register samples the offending word.
- R6: One inverted word inside an otherwise clean stream gives exactly two consecutive err_o cycles.
- R7: lock_o rises after 64 consecutive correct predictions, and not sooner.
- R8: While locked, the eighth error inside one 128-clock window clears lock_o. Fewer errors leave lock_o set.
- R9: link_err_o is high when the last 16 prediction results contain three or more errors. One or two errors never raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receive word clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| raw_i | input | 16 | Unaligned received word |
| lock_o | output | 1 | Prediction has been stable long enough |
| err_o | output | 1 | One-cycle pulse per PRBS prediction mismatch |
| link_err_o | output | 1 | Sustained error activity (burst filter) |
| data_o | output | 16 | Selected, bit-aligned word |

## Verification
A wrong selection index or dwell count shows up on data_o. With a constant single-one input, each candidate is a distinct rotation, so a misplaced step is visible within one 128-clock dwell. A wrong predictor or a wrong pipeline depth moves or changes the pattern of err_o pulses within five clocks of a corrupted word. A wrong lock counter shifts the relock edge by whole cycles, and that edge is checked at the exact clock. Burst-window errors show up as link_err_o being set or missing for corruption pairs spaced 15 and 16 words apart.

// File: rtl/prbs_align_pkg.sv
`timescale 1ns/1ps
package prbs_align_pkg;

  localparam int unsigned WORD_W    = 16;
  localparam int          TAP_LONG  = 15;
  localparam int          TAP_SHORT = 14;

  typedef logic [WORD_W-1:0] word_t;

  // Extend a word (bit WORD_W-1 earliest) by one word of the PRBS sequence.
  function automatic word_t prbs_next(input word_t cur);
    logic [2*WORD_W-1:0] seq;
    word_t               nxt;
    seq = '0;
    nxt = '0;
    for (int i = 0; i < int'(WORD_W); i++) begin
      seq[i] = cur[int'(WORD_W)-1-i];
    end
    for (int i = int'(WORD_W); i < 2*int'(WORD_W); i++) begin
      seq[i] = seq[i-TAP_LONG] ^ seq[i-TAP_SHORT];
    end
    for (int j = 0; j < int'(WORD_W); j++) begin
      nxt[int'(WORD_W)-1-j] = seq[int'(WORD_W)+j];
    end
    return nxt;
  endfunction

endpackage

// File: rtl/pam_rst_sync.sv
`timescale 1ns/1ps
module pam_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/pam_cand_bank.sv
`timescale 1ns/1ps
module pam_cand_bank
  import prbs_align_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_n,
  input  word_t                         raw_i,
  output logic [WORD_W-1:0][WORD_W-1:0] cand_o
);

  localparam int unsigned WIN_W = 2 * WORD_W;

  word_t                         in_q;
  word_t                         prev_q;
  logic [WIN_W-1:0]              window;
  logic [WORD_W-1:0][WORD_W-1:0] cand_d;
  logic [WORD_W-1:0][WORD_W-1:0] cand_q;
  logic                          samp_en;

  assign samp_en = 1'b1;
  assign window  = {prev_q, in_q};

  // Input capture: current and previous word.
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      prev_q <= '0;
    end else if (samp_en) begin
      in_q   <= raw_i;
      prev_q <= in_q;
    end
  end

  // One registered candidate per bit shift.
  for (genvar s = 0; s < int'(WORD_W); s++) begin : g_shift
    always_comb begin
      cand_d[s] = window[s +: WORD_W];
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
        cand_q[s] <= '0;
      end else if (samp_en) begin
        cand_q[s] <= cand_d[s];
      end
    end
  end

  assign cand_o = cand_q;

endmodule

// File: rtl/pam_align_ctrl.sv
`timescale 1ns/1ps
module pam_align_ctrl
  import prbs_align_pkg::*;
#(
  parameter int unsigned DWELL_CLKS = 128,
  localparam int unsigned SEL_W = $clog2(WORD_W),
  localparam int unsigned DW_W  = $clog2(DWELL_CLKS)
) (
  input  logic                          clk_i,
  input  logic                          rst_n,
  input  logic [WORD_W-1:0][WORD_W-1:0] cand_i,
  output word_t                         sel_word_o,
  output logic                          miss_o,
  output logic                          err_o,
  output logic [SEL_W-1:0]              sel_idx_o,
  output logic [DW_W-1:0]               dwell_o
);

  word_t             sel_q, sel_d;
  word_t             sel_prev_q;
  word_t             predict;
  logic              miss;
  logic              err_q;
  logic [DW_W-1:0]   dwell_q, dwell_d;
  logic [SEL_W-1:0]  idx_q, idx_d;
  logic              dwell_en, dwell_wrap, idx_en;

  // Candidate mux and predictor.
  always_comb begin
    sel_d   = cand_i[idx_q];
    predict = prbs_next(sel_prev_q);
    miss    = (predict != sel_q);
  end

  // Dwell timer: advances only on a mismatch.
  always_comb begin
    dwell_en   = miss;
    dwell_wrap = (dwell_q == DW_W'(DWELL_CLKS - 1));
    dwell_d    = dwell_wrap ? '0 : dwell_q + 1'b1;
    idx_en     = miss && dwell_wrap;
    idx_d      = (idx_q == SEL_W'(WORD_W - 1)) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= '0;
      sel_prev_q <= '0;
      err_q      <= 1'b0;
    end else begin
      sel_q      <= sel_d;
      sel_prev_q <= sel_q;
      err_q      <= miss;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      dwell_q <= '0;
    end else if (dwell_en) begin
      dwell_q <= dwell_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign sel_word_o = sel_q;
  assign miss_o     = miss;
  assign err_o      = err_q;
  assign sel_idx_o  = idx_q;
  assign dwell_o    = dwell_q;

endmodule

// File: rtl/pam_link_qual.sv
`timescale 1ns/1ps
module pam_link_qual #(
  parameter int unsigned LOCK_GOOD  = 64,
  parameter int unsigned LOSS_ERRS  = 8,
  parameter int unsigned LOSS_WIN   = 128,
  parameter int unsigned BURST_ERRS = 3,
  parameter int unsigned BURST_WIN  = 16
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic miss_i,
  output logic lock_o,
  output logic link_err_o
);

  localparam int unsigned GOOD_W = $clog2(LOCK_GOOD + 1);
  localparam int unsigned LOSS_W = $clog2(LOSS_ERRS + 1);
  localparam int unsigned WIN_W  = $clog2(LOSS_WIN);
  localparam int unsigned CNT_W  = $clog2(BURST_WIN + 1);

  logic [GOOD_W-1:0]    good_q, good_d;
  logic [LOSS_W-1:0]    loss_q, loss_d;
  logic [WIN_W-1:0]     win_q, win_d;
  logic                 lock_q, lock_d;
  logic [BURST_WIN-1:0] hist_q, hist_d;
  logic [CNT_W-1:0]     burst_cnt;
  logic                 link_q, link_d;
  logic                 win_last, loss_hit, lock_hit;

  // Lock acquisition and loss.
  always_comb begin
    win_last = (win_q == WIN_W'(LOSS_WIN - 1));
    win_d    = win_last ? '0 : win_q + 1'b1;

    if (miss_i) begin
      good_d = '0;
    end else if (good_q != GOOD_W'(LOCK_GOOD)) begin
      good_d = good_q + 1'b1;
    end else begin
      good_d = good_q;
    end

    if (win_last) begin
      loss_d = '0;
    end else if (miss_i && (loss_q != LOSS_W'(LOSS_ERRS))) begin
      loss_d = loss_q + 1'b1;
    end else begin
      loss_d = loss_q;
    end

    loss_hit = lock_q && miss_i && (loss_q >= LOSS_W'(LOSS_ERRS - 1));
    lock_hit = !lock_q && !miss_i && (good_q == GOOD_W'(LOCK_GOOD - 1));

    if (loss_hit) begin
      lock_d = 1'b0;
    end else if (lock_hit) begin
      lock_d = 1'b1;
    end else begin
      lock_d = lock_q;
    end
  end

  // Burst filter over the most recent results.
  always_comb begin
    hist_d    = {hist_q[BURST_WIN-2:0], miss_i};
    burst_cnt = '0;
    for (int i = 0; i < int'(BURST_WIN); i++) begin
      burst_cnt = burst_cnt + CNT_W'(hist_d[i]);
    end
    link_d = (burst_cnt >= CNT_W'(BURST_ERRS));
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      loss_q <= '0;
      win_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      good_q <= good_d;
      loss_q <= loss_d;
      win_q  <= win_d;
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      link_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      link_q <= link_d;
    end
  end

  assign lock_o     = lock_q;
  assign link_err_o = link_q;

endmodule

// File: rtl/prbs_align_mon.sv
`timescale 1ns/1ps
module prbs_align_mon
  import prbs_align_pkg::*;
#(
  parameter int unsigned DWELL_CLKS = 128,
  parameter int unsigned LOCK_GOOD  = 64,
  parameter int unsigned LOSS_ERRS  = 8,
  parameter int unsigned LOSS_WIN   = 128,
  parameter int unsigned BURST_ERRS = 3,
  parameter int unsigned BURST_WIN  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] raw_i,
  output logic              lock_o,
  output logic              err_o,
  output logic              link_err_o,
  output logic [WORD_W-1:0] data_o
);

  localparam int unsigned SEL_W = $clog2(WORD_W);
  localparam int unsigned DW_W  = $clog2(DWELL_CLKS);

  logic                          rst_n_sync;
  logic [WORD_W-1:0][WORD_W-1:0] cand;
  logic                          miss;
  logic [SEL_W-1:0]              sel_idx;
  logic [DW_W-1:0]               dwell_cnt;

  pam_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  pam_cand_bank u_bank (
    .clk_i  (clk_i),
    .rst_n  (rst_n_sync),
    .raw_i  (raw_i),
    .cand_o (cand)
  );

  pam_align_ctrl #(.DWELL_CLKS(DWELL_CLKS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_n      (rst_n_sync),
    .cand_i     (cand),
    .sel_word_o (data_o),
    .miss_o     (miss),
    .err_o      (err_o),
    .sel_idx_o  (sel_idx),
    .dwell_o    (dwell_cnt)
  );

  pam_link_qual #(
    .LOCK_GOOD  (LOCK_GOOD),
    .LOSS_ERRS  (LOSS_ERRS),
    .LOSS_WIN   (LOSS_WIN),
    .BURST_ERRS (BURST_ERRS),
    .BURST_WIN  (BURST_WIN)
  ) u_qual (
    .clk_i      (clk_i),
    .rst_n      (rst_n_sync),
    .miss_i     (miss),
    .lock_o     (lock_o),
    .link_err_o (link_err_o)
  );

endmodule

// File: rtl/prbs_align_mon_chk.sv
`timescale 1ns/1ps
module prbs_align_mon_chk
  import prbs_align_pkg::*;
#(
  parameter int unsigned DWELL_CLKS = 128,
  localparam int unsigned SEL_W = $clog2(WORD_W),
  localparam int unsigned DW_W  = $clog2(DWELL_CLKS)
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             lock_o,
  input logic             err_o,
  input logic             link_err_o,
  input logic [SEL_W-1:0] sel_idx,
  input logic [DW_W-1:0]  dwell
);

  // R3: selection only moves after a full dwell.
  a_r3_step_after_dwell: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sel_idx != $past(sel_idx)) |-> ($past(dwell) == DW_W'(DWELL_CLKS - 1) && err_o));

  // R3: selection moves by one and wraps.
  a_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sel_idx != $past(sel_idx)) |->
      (sel_idx == (($past(sel_idx) == SEL_W'(WORD_W - 1)) ? '0 : $past(sel_idx) + 1'b1)));

  // R4: timer frozen on a correct prediction.
  a_r4_freeze_on_match: assert property (@(posedge clk_i) disable iff (!rst_n)
    !err_o |-> $stable(dwell));

  // R7: lock rises only on a clean prediction.
  a_r7_lock_rise_clean: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(lock_o) |-> !err_o);

  // R8: lock falls only on an error.
  a_r8_lock_fall_on_err: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(lock_o) |-> err_o);

  // R9: link error rises together with an error pulse.
  a_r9_link_rise_on_err: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(link_err_o) |-> err_o);

endmodule

bind prbs_align_mon prbs_align_mon_chk #(.DWELL_CLKS(DWELL_CLKS)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n_sync),
  .lock_o     (lock_o),
  .err_o      (err_o),
  .link_err_o (link_err_o),
  .sel_idx    (sel_idx),
  .dwell      (dwell_cnt)
);

// File: tb/prbs_align_mon_bench.sv
`timescale 1ns/1ps
module prbs_align_mon_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] raw_i;
  logic        lock_o, err_o, link_err_o;
  logic [15:0] data_o;

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  logic [14:0] lfsr  = 15'h5A3C;
  logic [15:0] past_w [4];

  typedef struct packed {
    logic [7:0] gap;
    logic [3:0] errs;
    logic       link;
  } trial_t;

  // Corruption pairs: gap 0 is a single inverted word.
  localparam trial_t TRIALS [6] = '{
    '{gap: 8'd0,  errs: 4'd2, link: 1'b0},
    '{gap: 8'd1,  errs: 4'd3, link: 1'b1},
    '{gap: 8'd2,  errs: 4'd4, link: 1'b1},
    '{gap: 8'd15, errs: 4'd4, link: 1'b1},
    '{gap: 8'd16, errs: 4'd4, link: 1'b0},
    '{gap: 8'd40, errs: 4'd4, link: 1'b0}
  };

  prbs_align_mon u_prbs_align_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .raw_i      (raw_i),
    .lock_o     (lock_o),
    .err_o      (err_o),
    .link_err_o (link_err_o),
    .data_o     (data_o)
  );

  always #2.5 clk_i = ~clk_i;

  task automatic gen(output logic [15:0] w);
    logic nb;
    w = '0;
    for (int b = 0; b < 16; b++) begin
      nb   = lfsr[14] ^ lfsr[13];
      lfsr = {lfsr[13:0], nb};
      w    = {w[14:0], nb};
    end
  endtask

  task automatic drive(input logic [15:0] w);
    @(negedge clk_i);
    raw_i     = w;
    past_w[3] = past_w[2];
    past_w[2] = past_w[1];
    past_w[1] = past_w[0];
    past_w[0] = w;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rotr(input logic [15:0] x, input int s);
    if (s == 0) return x;
    return (x >> s) | (x << (16 - s));
  endfunction

  initial begin
    logic [15:0] w;
    int erc;
    bit lk;
    for (int k = 0; k < 4; k++) past_w[k] = '0;
    rst_ni = 1'b0;
    raw_i  = '0;
    for (int k = 0; k < 3; k++) begin gen(w); drive(w); end
    // R1: reset state
    check(lock_o == 0 && err_o == 0 && link_err_o == 0, "R1 flags in reset",
          {lock_o, err_o, link_err_o}, 0);
    check(data_o == 16'h0000, "R1 data in reset", data_o, 0);

    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int t = 0; t < 150; t++) begin
      gen(w); drive(w);
      if (t == 40) check(lock_o == 0, "R7 no early lock", lock_o, 0);
    end
    check(lock_o == 1, "R7 lock after clean run", lock_o, 1);
    check(err_o == 0, "R5 clean stream no error", err_o, 0);
    check(data_o == past_w[3], "R4 candidate 0 held", data_o, past_w[3]);

    // Table of corruption patterns
    for (int tr = 0; tr < 6; tr++) begin
      for (int k = 0; k < 160; k++) begin gen(w); drive(w); end
      check(data_o == past_w[3], "R4 alignment kept", data_o, past_w[3]);
      erc = 0;
      lk  = 1'b0;
      for (int i = 0; i <= int'(TRIALS[tr].gap) + 40; i++) begin
        gen(w);
        if (i == 0 || (TRIALS[tr].gap != 0 && i == int'(TRIALS[tr].gap))) w = ~w;
        drive(w);
        erc += int'(err_o);
        lk  |= link_err_o;
        if (tr == 0) begin
          if (i == 3) begin
            check(data_o == past_w[3], "R2 corrupted word on data", data_o, past_w[3]);
            check(err_o == 0, "R5 no pulse before latency", err_o, 0);
          end
          if (i == 4) check(err_o == 1, "R5 pulse at four clocks", err_o, 1);
          if (i == 5) check(err_o == 1, "R6 second pulse", err_o, 1);
          if (i == 6) check(err_o == 0, "R6 pulse ends", err_o, 0);
        end
      end
      check(erc == int'(TRIALS[tr].errs), $sformatf("R6 R9 error count gap %0d", TRIALS[tr].gap),
            erc, TRIALS[tr].errs);
      check(lk == TRIALS[tr].link, $sformatf("R9 link filter gap %0d", TRIALS[tr].gap),
            lk, TRIALS[tr].link);
      check(lock_o == 1, "R8 lock kept under few errors", lock_o, 1);
    end

    // R8: sustained garbage drops lock
    for (int k = 0; k < 20; k++) drive(16'h0001);
    check(lock_o == 0, "R8 lock lost", lock_o, 0);

    // R7: exact relock edge
    for (int j = 0; j <= 68; j++) begin
      gen(w); drive(w);
      if (j == 67) check(lock_o == 0, "R7 lock not at 63 matches", lock_o, 0);
      if (j == 68) check(lock_o == 1, "R7 lock at 64 matches", lock_o, 1);
    end

    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    raw_i  = 16'h0001;
    #1;
    check(lock_o == 0 && err_o == 0 && link_err_o == 0 && data_o == 0,
          "R1 async clear", {lock_o, err_o, link_err_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R3: candidate walk with a constant single-one word
    for (int t = 0; t <= 16 * 128 + 64; t++) begin
      drive(16'h0001);
      if (t >= 64 && ((t - 64) % 128) == 0) begin
        check(data_o == rotr(16'h0001, ((t - 64) / 128) % 16),
              $sformatf("R3 candidate %0d", (t - 64) / 128), data_o,
              rotr(16'h0001, ((t - 64) / 128) % 16));
      end
      if (t == 64) begin
        check(lock_o == 0, "R7 no lock on bad stream", lock_o, 0);
        check(link_err_o == 1, "R9 sustained errors flagged", link_err_o, 1);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule